// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge/Level Capture

This block collects up to 32 interrupt request lines into a status register, masks them with an enable register, and drives a single interrupt line to the processor. Each line is fixed at build time as edge-sensitive or level-sensitive by the `KIND` parameter. Software uses a small 32-bit register bus to set and clear enable bits atomically through write-one alias registers, to acknowledge captured requests, to read which lines are pending and which one to service next, and to arm the output through a two-bit master control register.

The bus is word-addressed on `bus_addr[4:2]`. A write takes effect on the clock edge where `bus_wr` is high. A read returns its data on `bus_rdata` one cycle after the edge where `bus_rd` is high. Bits at or above `N` read as zero.

The master control is a four-state machine. `MS_DISARMED` means both bits are clear, `MS_SOFT` means only the software enable is set, `MS_HWHOLD` means only the hardware-enable latch is set, and `MS_LIVE` means both are set. The machine changes state only on a write to the master register. From `MS_DISARMED` or `MS_SOFT`, the written bit pair `{hw, sw}` selects the next state directly. From `MS_HWHOLD` or `MS_LIVE`, the next state is `MS_LIVE` if bit 0 is written as one and `MS_HWHOLD` otherwise, so the hardware latch is never released by a write. Reset returns the machine to `MS_DISARMED`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the status, enable and master registers read zero, the vector register reads 0xFFFFFFFF and `irq_out` is low.
- R2: A write to the enable register (word 2, byte offset 0x08) replaces its contents, and reading it back returns the value written.
- R3: Writing to the set alias (byte offset 0x10) sets every enable bit whose write-data bit is one. Enable bits whose write-data bit is zero keep their value.
- R4: Writing to the clear alias (byte offset 0x14) clears every enable bit whose write-data bit is one. Enable bits whose write-data bit is zero keep their value.
- R5: An input whose `KIND` bit is 1 sets its status bit once per rising edge. If that input stays high after the bit is acknowledged, the status bit stays clear.
- R6: An input whose `KIND` bit is 0 sets its status bit while the input is high. If the input is still high when the bit is acknowledged, the status bit reads clear for one cycle and is set again in the next cycle. A later fall of the input does not clear the bit.
- R7: Writing ones to the acknowledge register (byte offset 0x0C) clears the matching status bits, and writing all ones clears every status bit. Writes to the status (0x00), pending (0x04) and vector (0x18) registers change nothing.
- R8: The pending register (byte offset 0x04) reads status AND enable.
- R9: The vector register (byte offset 0x18) reads the lowest index whose pending bit is set, or 0xFFFFFFFF when no bit is pending.
- R10: In the master register (byte offset 0x1C), bit 0 is a software enable that can be written either way. Bit 1 is a hardware enable that stays set from the first write of one until reset. A read returns `{bit1, bit0}`.
- R11: `irq_out` is high exactly when at least one pending bit is set and both master bits are set.
- R12: Register bits at or above `N` read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| irq_in | input | N | Interrupt request lines |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The bench sweeps every pattern of the eight request lines, with lines 0–3 level-sensitive and lines 4–7 edge-sensitive, against two enable masks, and checks the pending word, the vector and `irq_out` for each combination. An encoder that favours the highest index, or that reports zero for an empty set, would return the wrong vector. A pending register that ignored the enable mask would also be caught.

The bench acknowledges a line while its input is still high. For a level line it expects the status bit to read clear and then set again on the following read. For an edge line it expects the bit to stay clear. A design that gave the two kinds the same rule would fail one of these checks.

The bench walks the master register through all four states and checks that a write of zero cannot release the hardware bit. A design that let the hardware bit be cleared, or that raised the output with only one master bit set, would be caught. Writes of all ones confirm that unused bits stay zero, and writes to the read-only words confirm that they change nothing.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_SETEN  = 3'd4,
        SEL_CLREN  = 3'd5,
        SEL_VECTOR = 3'd6,
        SEL_MASTER = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        MS_DISARMED = 2'b00,
        MS_SOFT     = 2'b01,
        MS_HWHOLD   = 2'b10,
        MS_LIVE     = 2'b11
    } master_state_e;

endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
    parameter int          N    = 32,
    parameter logic [31:0] KIND = 32'hFFFF_0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] ack_mask,
    output logic [N-1:0] status
);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic nxt;
        if (KIND[i]) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= irq_in[i];
            end
            // an edge arriving with an ack is kept
            always_comb nxt = (status[i] & ~ack_mask[i]) | (irq_in[i] & ~prev_q);
        end else begin : g_level
            // ack wins for one cycle; a held level re-sets next cycle
            always_comb nxt = (status[i] | irq_in[i]) & ~ack_mask[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status[i] <= 1'b0;
            else        status[i] <= nxt;
        end
    end

endmodule

// File: rtl/intc_lowest.sv
module intc_lowest #(
    parameter int N    = 32,
    parameter int IDXW = 5
) (
    input  logic [N-1:0]    pend,
    output logic            found,
    output logic [IDXW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = i[IDXW-1:0];
            end
        end
    end

endmodule

// File: rtl/intc_master_fsm.sv
module intc_master_fsm
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_master,
    input  logic [1:0] wbits,
    output logic       sw_en,
    output logic       hw_en
);

    master_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_master) begin
            unique case (state_q)
                MS_DISARMED, MS_SOFT: state_d = master_state_e'(wbits);
                MS_HWHOLD, MS_LIVE:   state_d = wbits[0] ? MS_LIVE : MS_HWHOLD;
                default:              state_d = MS_DISARMED;
            endcase
        end
    end

    always_comb begin
        sw_en = 1'b0;
        hw_en = 1'b0;
        unique case (state_q)
            MS_DISARMED: begin sw_en = 1'b0; hw_en = 1'b0; end
            MS_SOFT:     begin sw_en = 1'b1; hw_en = 1'b0; end
            MS_HWHOLD:   begin sw_en = 1'b0; hw_en = 1'b1; end
            MS_LIVE:     begin sw_en = 1'b1; hw_en = 1'b1; end
            default:     begin sw_en = 1'b0; hw_en = 1'b0; end
        endcase
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import intc_pkg::*;
#(
    parameter int          N      = 32,
    parameter logic [31:0] KIND   = 32'hFFFF_0000,
    parameter int          ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N-1:0]      irq_in,
    output logic              irq_out
);

    localparam int IDXW = (N > 1) ? $clog2(N) : 1;

    reg_sel_e     sel;
    logic [N-1:0] wmask;
    logic [N-1:0] status_q;
    logic [N-1:0] enable_q;
    logic [N-1:0] pend;
    logic [N-1:0] ack_mask;
    logic         found;
    logic [IDXW-1:0] idx;
    logic [31:0]  vec_word;
    logic         sw_en, hw_en;
    logic [31:0]  rd_word;

    assign sel      = reg_sel_e'(bus_addr[4:2]);
    assign wmask    = bus_wdata[N-1:0];
    assign ack_mask = (bus_wr && sel == SEL_ACK) ? wmask : '0;
    assign pend     = status_q & enable_q;

    intc_capture #(.N(N), .KIND(KIND)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .ack_mask (ack_mask),
        .status   (status_q)
    );

    intc_lowest #(.N(N), .IDXW(IDXW)) u_lowest (
        .pend  (pend),
        .found (found),
        .idx   (idx)
    );

    intc_master_fsm u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_master (bus_wr && sel == SEL_MASTER),
        .wbits     (bus_wdata[1:0]),
        .sw_en     (sw_en),
        .hw_en     (hw_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_ENABLE: enable_q <= wmask;
                SEL_SETEN:  enable_q <= enable_q | wmask;
                SEL_CLREN:  enable_q <= enable_q & ~wmask;
                default:    enable_q <= enable_q;
            endcase
        end
    end

    always_comb begin
        vec_word = '1;
        if (found) begin
            vec_word = '0;
            vec_word[IDXW-1:0] = idx;
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_STATUS: rd_word[N-1:0] = status_q;
            SEL_PEND:   rd_word[N-1:0] = pend;
            SEL_ENABLE: rd_word[N-1:0] = enable_q;
            SEL_VECTOR: rd_word        = vec_word;
            SEL_MASTER: rd_word[1:0]   = {hw_en, sw_en};
            default:    rd_word        = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    assign irq_out = (|pend) & sw_en & hw_en;

endmodule

// File: rtl/intc_props.sv
module intc_props #(
    parameter int N      = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [N-1:0]      status_q,
    input logic [N-1:0]      enable_q,
    input logic [31:0]       vec_word,
    input logic              sw_en,
    input logic              hw_en,
    input logic              irq_out
);

    logic [2:0] wsel;
    assign wsel = bus_addr[4:2];

    // R3
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wsel == 3'd4) |=>
            ((enable_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

    // R4
    enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wsel == 3'd5) |=> ((enable_q & $past(bus_wdata[N-1:0])) == '0));

    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && wsel == 3'd3) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R10
    hw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_en |=> hw_en);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (sw_en && hw_en && ((status_q & enable_q) != '0)));

    // R9
    vec_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & enable_q) == '0) |-> (vec_word == 32'hFFFF_FFFF));

endmodule

bind irq_vector_ctrl intc_props #(.N(N), .ADDR_W(ADDR_W)) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .vec_word  (vec_word),
    .sw_en     (sw_en),
    .hw_en     (hw_en),
    .irq_out   (irq_out)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;

    localparam int          N    = 8;
    localparam logic [31:0] KIND = 32'h0000_00F0;

    localparam logic [4:0] A_STATUS = 5'h00, A_PEND = 5'h04, A_EN = 5'h08, A_ACK = 5'h0C,
                           A_SET = 5'h10, A_CLR = 5'h14, A_VEC = 5'h18, A_MST = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_vector_ctrl #(.N(N), .KIND(KIND), .ADDR_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // tasks start and end at a falling edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] lowest(input logic [7:0] p);
        logic [31:0] r;
        r = 32'hFFFF_FFFF;
        for (int i = 7; i >= 0; i--) if (p[i]) r = i;
        return r;
    endfunction

    initial begin
        logic [31:0] v;
        logic [7:0]  e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_STATUS, v); chk("R1 status", v, 0);
        rd(A_EN, v);     chk("R1 enable", v, 0);
        rd(A_MST, v);    chk("R1 master", v, 0);
        rd(A_VEC, v);    chk("R1 vector", v, 32'hFFFF_FFFF);
        chk("R1 irq", {31'b0, irq_out}, 0);

        // R2 direct write; R12 upper bits
        wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, v); chk("R12 enable width", v, 32'h0000_00FF);
        wr(A_EN, 32'h5A);        rd(A_EN, v); chk("R2 enable write", v, 32'h5A);

        // R3 / R4 alias sweeps
        wr(A_EN, 0);
        for (int i = 0; i < N; i++) begin
            wr(A_SET, 32'h1 << i); rd(A_EN, v);
            chk("R3 set alias", v, (32'h2 << i) - 1);
        end
        for (int i = 0; i < N; i++) begin
            wr(A_CLR, 32'h1 << i); rd(A_EN, v);
            chk("R4 clear alias", v, 32'hFF & ~((32'h2 << i) - 1));
        end
        wr(A_SET, 0); rd(A_EN, v); chk("R3 zero write", v, 0);
        wr(A_EN, 32'h3C); wr(A_CLR, 0); rd(A_EN, v); chk("R4 zero write", v, 32'h3C);

        // R10 master state walk
        wr(A_ACK, 32'hFFFF_FFFF);
        wr(A_EN, 32'hFF);
        irq_in = 8'h01; @(negedge clk); irq_in = 8'h00; @(negedge clk);
        wr(A_MST, 1); rd(A_MST, v); chk("R10 soft only", v, 1);
        chk("R11 irq soft only", {31'b0, irq_out}, 0);
        wr(A_MST, 2); rd(A_MST, v); chk("R10 hw only", v, 2);
        chk("R11 irq hw only", {31'b0, irq_out}, 0);
        wr(A_MST, 3); rd(A_MST, v); chk("R10 live", v, 3);
        chk("R11 irq live", {31'b0, irq_out}, 1);
        wr(A_MST, 0); rd(A_MST, v); chk("R10 hw sticky", v, 2);
        chk("R11 irq after soft off", {31'b0, irq_out}, 0);
        wr(A_MST, 1); rd(A_MST, v); chk("R10 relive", v, 3);

        // R7 read-only words ignore writes
        wr(A_STATUS, 0); wr(A_PEND, 0); wr(A_VEC, 0);
        rd(A_STATUS, v); chk("R7 status write ignored", v, 1);
        wr(A_ACK, 32'hFFFF_FFFF); rd(A_STATUS, v); chk("R7 ack all", v, 0);
        chk("R11 irq cleared", {31'b0, irq_out}, 0);

        // R6 level line held through ack
        irq_in = 8'h01; @(negedge clk);
        wr(A_ACK, 32'h1);
        rd(A_STATUS, v); chk("R6 cleared one cycle", v, 0);
        rd(A_STATUS, v); chk("R6 re-set", v, 1);
        irq_in = 8'h00; @(negedge clk);
        rd(A_STATUS, v); chk("R6 held after fall", v, 1);
        wr(A_ACK, 32'h1);

        // R5 edge line held through ack
        irq_in = 8'h10; @(negedge clk);
        rd(A_STATUS, v); chk("R5 edge set", v, 32'h10);
        wr(A_ACK, 32'h10);
        rd(A_STATUS, v); chk("R5 cleared", v, 0);
        rd(A_STATUS, v); chk("R5 stays clear while high", v, 0);
        irq_in = 8'h00; @(negedge clk);
        irq_in = 8'h10; @(negedge clk);
        rd(A_STATUS, v); chk("R5 new edge", v, 32'h10);
        irq_in = 8'h00; @(negedge clk);

        // R7 partial ack keeps others
        irq_in = 8'h33; @(negedge clk); irq_in = 8'h00; @(negedge clk);
        wr(A_ACK, 32'h22); rd(A_STATUS, v); chk("R7 partial ack", v, 32'h11);

        // R8 R9 R11 exhaustive sweep of line patterns
        for (int p = 0; p < 256; p++) begin
            irq_in = 8'h00; @(negedge clk);
            wr(A_ACK, 32'hFFFF_FFFF);
            irq_in = p[7:0]; @(negedge clk);
            irq_in = 8'h00; @(negedge clk);
            for (int k = 0; k < 2; k++) begin
                e = (k == 0) ? 8'hFF : (~p[7:0] ^ 8'h3C);
                wr(A_EN, {24'b0, e});
                rd(A_PEND, v); chk("R8 pending", v, {24'b0, p[7:0] & e});
                rd(A_VEC, v);  chk("R9 vector", v, lowest(p[7:0] & e));
                chk("R11 irq", {31'b0, irq_out}, {31'b0, |(p[7:0] & e)});
            end
        end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule